// File: doc/BRIEF.md
# Spare-Area Status Gap Shaper

This block sits on a byte stream between a spare-area buffer and an error-correction engine's spare port. A page of spare data is made of N chunks of S bytes each. In insert direction the block forwards each chunk unchanged and then emits four gap bytes of value 0x00 after it, so the engine sees every chunk followed by room for its status. In strip direction the block takes the widened stream, forwards the S bytes of each chunk, and drops the four gap bytes after it. It keeps the first gap byte of chunk k as that chunk's status in entry k of a status array.

Both sides use valid/ready handshakes. The output can be held off at any time without losing a byte. The direction, the chunk size S and the chunk count N are inputs. They are captured on the first byte of a page and held until the page's last gap byte has passed. The final output byte of a page carries an end-of-page flag.

Top module: `spare_gap_shaper`

## Requirements
- R1: After reset, out_valid and out_last are low while no input is offered, every status entry reads 0x00, and the block waits for the first byte of a page.
- R2: With mode_i = 0 (insert), the S bytes of each chunk leave in arrival order and unchanged, followed by exactly four bytes of 0x00, for all N chunks.
- R3: In insert direction, in_ready stays low and out_valid stays high while gap bytes are emitted.
- R4: With mode_i = 1 (strip), the block forwards the first S bytes of every S+4 input bytes in order and drops the following four. During the dropped bytes in_ready is high and out_valid is low.
- R5: In strip direction, the first dropped byte after chunk k is written to status entry k (stat_o bits 8k+7 down to 8k). No other byte changes any entry, and entries at or beyond N keep their values.
- R6: out_last is high on exactly one output byte per page. In insert direction this is the fourth gap byte of chunk N-1. In strip direction it is the last data byte of chunk N-1.
- R7: While out_ready is low, no byte is consumed or lost. An offered output byte stays valid and unchanged until it is taken.
- R8: mode_i, chunk_bytes_i and chunk_count_i are sampled with the first byte of a page. Changes to them later in the page have no effect.
- R9: The extreme sizes S = 1, N = 1 and S = MAX_CHUNK_BYTES, N = MAX_CHUNKS give the same framing as the middle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = insert gaps, 1 = strip gaps; taken at page start |
| chunk_bytes_i | input | $clog2(MAX_CHUNK_BYTES+1) | Chunk size S in bytes (at least 1) |
| chunk_count_i | input | $clog2(MAX_CHUNKS+1) | Chunks per page N (1 to MAX_CHUNKS) |
| in_valid | input | 1 | Input byte offered |
| in_data | input | DATA_W | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Output byte offered |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Final output byte of the page |
| out_ready | input | 1 | Downstream takes the output byte |
| stat_o | output | MAX_CHUNKS*DATA_W | Captured status bytes, entry k in bits 8k+7:8k |

## Verification
The bench builds the block with MAX_CHUNK_BYTES = 16 and MAX_CHUNKS = 4. With these values the largest page (S = 16, N = 4) fills the whole status array and the largest chunk counter value. A short strip page that follows it then shows that the upper entries are left untouched. The smallest page (S = 1, N = 1) makes every data byte the last byte of its chunk, so gap entry and page end fall on the same step. Random and alternating ready patterns land stalls on data bytes, on gap bytes and on the last byte of a page.

// File: rtl/spare_gap_pkg.sv
package spare_gap_pkg;

  typedef enum logic {
    DIR_INSERT = 1'b0,
    DIR_STRIP  = 1'b1
  } dir_e;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_GAP  = 1'b1
  } phase_e;

endpackage

// File: rtl/spare_gap_seq.sv
module spare_gap_seq
  import spare_gap_pkg::*;
#(
  parameter int CW      = 7,
  parameter int NW      = 5,
  parameter int GW      = 2,
  parameter int GAP_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dir_e          dir_i,
  input  logic [CW-1:0] s_i,
  input  logic [NW-1:0] n_i,
  input  logic          step_i,
  output dir_e          dir_o,
  output phase_e        phase_o,
  output logic [CW-1:0] byte_o,
  output logic [NW-1:0] chunk_o,
  output logic [GW-1:0] gap_o,
  output logic          start_o,
  output logic          last_data_o,
  output logic          last_gap_o,
  output logic          last_chunk_o
);

  // configuration held for the page, loaded on the first step
  dir_e          dir_q,   dir_n;
  logic [CW-1:0] s_q,     s_n;
  logic [NW-1:0] n_q,     n_n;
  logic          start_q, start_n;

  // position within the page
  phase_e        phase_q, phase_n;
  logic [CW-1:0] byte_q,  byte_n;
  logic [NW-1:0] chunk_q, chunk_n;
  logic [GW-1:0] gap_q,   gap_n;

  dir_e          dir_eff;
  logic [CW-1:0] s_eff;
  logic [NW-1:0] n_eff;
  logic          last_data, last_gap, last_chunk;

  // between pages the live inputs apply, inside a page the held copy
  assign dir_eff = start_q ? dir_i : dir_q;
  assign s_eff   = start_q ? s_i   : s_q;
  assign n_eff   = start_q ? n_i   : n_q;

  assign last_data  = (byte_q  == s_eff - CW'(1));
  assign last_gap   = (gap_q   == GW'(GAP_LEN - 1));
  assign last_chunk = (chunk_q == n_eff - NW'(1));

  always_comb begin
    dir_n   = dir_q;
    s_n     = s_q;
    n_n     = n_q;
    start_n = start_q;
    phase_n = phase_q;
    byte_n  = byte_q;
    chunk_n = chunk_q;
    gap_n   = gap_q;
    if (step_i) begin
      if (start_q) begin
        dir_n   = dir_i;
        s_n     = s_i;
        n_n     = n_i;
        start_n = 1'b0;
      end
      if (phase_q == PH_DATA) begin
        if (last_data) begin
          phase_n = PH_GAP;
          byte_n  = '0;
        end else begin
          byte_n  = byte_q + CW'(1);
        end
      end else begin
        if (last_gap) begin
          phase_n = PH_DATA;
          gap_n   = '0;
          if (last_chunk) begin
            chunk_n = '0;
            start_n = 1'b1;
          end else begin
            chunk_n = chunk_q + NW'(1);
          end
        end else begin
          gap_n = gap_q + GW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_INSERT;
      s_q     <= '0;
      n_q     <= '0;
      start_q <= 1'b1;
      phase_q <= PH_DATA;
      byte_q  <= '0;
      chunk_q <= '0;
      gap_q   <= '0;
    end else if (step_i) begin
      dir_q   <= dir_n;
      s_q     <= s_n;
      n_q     <= n_n;
      start_q <= start_n;
      phase_q <= phase_n;
      byte_q  <= byte_n;
      chunk_q <= chunk_n;
      gap_q   <= gap_n;
    end
  end

  assign dir_o        = dir_eff;
  assign phase_o      = phase_q;
  assign byte_o       = byte_q;
  assign chunk_o      = chunk_q;
  assign gap_o        = gap_q;
  assign start_o      = start_q;
  assign last_data_o  = last_data;
  assign last_gap_o   = last_gap;
  assign last_chunk_o = last_chunk;

  // R9: the byte position never runs past the chunk size in use
  a_r9_byte_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && s_eff != '0) |-> (byte_q < s_eff));

  // R8: inside a page the held configuration does not move
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !$past(start_q)) |-> ($stable(dir_q) && $stable(s_q) && $stable(n_q)));

endmodule

// File: rtl/spare_gap_route.sv
module spare_gap_route
  import spare_gap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dir_e              dir_i,
  input  phase_e            phase_i,
  input  logic              last_data_i,
  input  logic              last_gap_i,
  input  logic              last_chunk_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              step_o
);

  always_comb begin
    if (phase_i == PH_DATA) begin
      // chunk bytes pass straight through in both directions
      out_valid = in_valid;
      out_data  = in_data;
      in_ready  = out_ready;
      step_o    = in_valid && out_ready;
      out_last  = (dir_i == DIR_STRIP) && last_data_i && last_chunk_i;
    end else if (dir_i == DIR_INSERT) begin
      // gap bytes are made here; upstream is held off
      out_valid = 1'b1;
      out_data  = '0;
      in_ready  = 1'b0;
      step_o    = out_ready;
      out_last  = last_gap_i && last_chunk_i;
    end else begin
      // gap bytes are swallowed; downstream sees nothing
      out_valid = 1'b0;
      out_data  = '0;
      in_ready  = 1'b1;
      step_o    = in_valid;
      out_last  = 1'b0;
    end
  end

endmodule

// File: rtl/spare_gap_stat.sv
module spare_gap_stat #(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 16,
  parameter int NW      = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [NW-1:0]             idx_i,
  input  logic [DATA_W-1:0]         d_i,
  output logic [ENTRIES*DATA_W-1:0] stat_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] q;

    assign hit = we_i && (idx_i == NW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= d_i;
      end
    end

    assign stat_o[g*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/spare_gap_shaper.sv
module spare_gap_shaper
  import spare_gap_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int MAX_CHUNK_BYTES = 64,
  parameter int MAX_CHUNKS      = 16,
  parameter int GAP_LEN         = 4,
  localparam int CW = $clog2(MAX_CHUNK_BYTES + 1),
  localparam int NW = $clog2(MAX_CHUNKS + 1),
  localparam int GW = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode_i,
  input  logic [CW-1:0]                chunk_bytes_i,
  input  logic [NW-1:0]                chunk_count_i,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_last,
  input  logic                         out_ready,
  output logic [MAX_CHUNKS*DATA_W-1:0] stat_o
);

  dir_e          dir;
  phase_e        phase;
  logic [CW-1:0] byte_cnt;
  logic [NW-1:0] chunk_cnt;
  logic [GW-1:0] gap_cnt;
  logic          page_start;
  logic          last_data, last_gap, last_chunk;
  logic          step;
  logic          stat_we;

  spare_gap_seq #(
    .CW(CW), .NW(NW), .GW(GW), .GAP_LEN(GAP_LEN)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_i        (dir_e'(mode_i)),
    .s_i          (chunk_bytes_i),
    .n_i          (chunk_count_i),
    .step_i       (step),
    .dir_o        (dir),
    .phase_o      (phase),
    .byte_o       (byte_cnt),
    .chunk_o      (chunk_cnt),
    .gap_o        (gap_cnt),
    .start_o      (page_start),
    .last_data_o  (last_data),
    .last_gap_o   (last_gap),
    .last_chunk_o (last_chunk)
  );

  spare_gap_route #(
    .DATA_W(DATA_W)
  ) u_route (
    .dir_i        (dir),
    .phase_i      (phase),
    .last_data_i  (last_data),
    .last_gap_i   (last_gap),
    .last_chunk_i (last_chunk),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_last     (out_last),
    .out_ready    (out_ready),
    .step_o       (step)
  );

  // the first swallowed gap byte of a chunk is its status
  assign stat_we = (dir == DIR_STRIP) && (phase == PH_GAP) && (gap_cnt == '0) && in_valid;

  spare_gap_stat #(
    .DATA_W(DATA_W), .ENTRIES(MAX_CHUNKS), .NW(NW)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (stat_we),
    .idx_i  (chunk_cnt),
    .d_i    (in_data),
    .stat_o (stat_o)
  );

  // R7: a refused output leaves the data position where it was
  a_r7_stall_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !out_ready) |=> ($stable(byte_cnt) && $stable(chunk_cnt)));

  // R6: in insert direction the flagged byte closes the page
  a_r6_insert_last_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && dir == DIR_INSERT) |=> page_start);

  // R6: in strip direction the flagged byte is followed by the final gap
  a_r6_strip_last_opens_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && dir == DIR_STRIP) |=> (phase == PH_GAP && gap_cnt == '0));

  // R5: the status array only changes on a captured gap byte
  a_r5_stat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> $stable(stat_o));

endmodule

// File: tb/sim_spare_gap_shaper.sv
module sim_spare_gap_shaper;

  localparam int DW = 8;
  localparam int MS = 16;
  localparam int MN = 4;
  localparam int CW = $clog2(MS + 1);
  localparam int NW = $clog2(MN + 1);

  typedef struct {
    logic [7:0] d;
    logic       last;
    logic       gap;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              mode_i;
  logic [CW-1:0]     chunk_bytes_i;
  logic [NW-1:0]     chunk_count_i;
  logic              in_valid;
  logic [DW-1:0]     in_data;
  logic              in_ready;
  logic              out_valid;
  logic [DW-1:0]     out_data;
  logic              out_last;
  logic              out_ready;
  logic [MN*DW-1:0]  stat_o;

  spare_gap_shaper #(
    .DATA_W(DW), .MAX_CHUNK_BYTES(MS), .MAX_CHUNKS(MN), .GAP_LEN(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .chunk_bytes_i(chunk_bytes_i), .chunk_count_i(chunk_count_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .stat_o(stat_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  exp_t       q[$];
  int         nchk = 0;
  int         nfail = 0;
  int         rdy_mode = 0;
  string      cur_tag = "";
  logic [7:0] exp_stat [MN];
  int         cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ready pattern, changed away from the rising edge
  always @(negedge clk) begin
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 4) != 0;
      default: out_ready = ~out_ready;
    endcase
  end

  // monitor: samples one ns before the rising edge
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = '0;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data, {cur_tag, " R7 stalled byte held"},
              int'(out_data), int'(prev_data));
      if (q.size() != 0 && q[0].gap)
        check(!in_ready && out_valid, {cur_tag, " R3 input held in gap"},
              int'({in_ready, out_valid}), 1);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, {cur_tag, " R2 R4 unexpected byte"}, int'(out_data), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_data == e.d, {cur_tag, " data"}, int'(out_data), int'(e.d));
          check(out_last == e.last, {cur_tag, " R6 last flag"}, int'(out_last), int'(e.last));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // driver: offers a byte at the falling edge, holds it until accepted
  task automatic send_byte(input logic [7:0] d);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    ok = 1'b0;
    while (!ok) begin
      #3;
      ok = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run_page(input bit dir, input int s, input int n, input string tag);
    cur_tag       = tag;
    mode_i        = dir;
    chunk_bytes_i = CW'(s);
    chunk_count_i = NW'(n);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < s; b++) begin
        exp_t e;
        e.d    = 8'($urandom);
        e.last = dir && (k == n - 1) && (b == s - 1);
        e.gap  = 1'b0;
        q.push_back(e);
        send_byte(e.d);
        if (k == 0 && b == 0) begin
          // R8: disturb the configuration inside the page
          mode_i        = ~dir;
          chunk_bytes_i = CW'((s % 7) + 2);
          chunk_count_i = NW'((n % 3) + 1);
        end
      end
      if (!dir) begin
        for (int g = 0; g < 4; g++) begin
          exp_t e;
          e.d    = 8'h00;
          e.last = (k == n - 1) && (g == 3);
          e.gap  = 1'b1;
          q.push_back(e);
        end
      end else begin
        for (int g = 0; g < 4; g++) begin
          logic [7:0] sd;
          sd = 8'($urandom);
          if (g == 0) exp_stat[k] = sd;
          send_byte(sd);
        end
      end
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    #3;
    if (dir) begin
      for (int k = 0; k < MN; k++)
        check(stat_o[k*8 +: 8] == exp_stat[k], {tag, " R5 status entry"},
              int'(stat_o[k*8 +: 8]), int'(exp_stat[k]));
    end
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < MN; k++) exp_stat[k] = 8'h00;
    rst_n         = 1'b0;
    mode_i        = 1'b0;
    chunk_bytes_i = '0;
    chunk_count_i = '0;
    in_valid      = 1'b0;
    in_data       = '0;
    out_ready     = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check(!out_valid && !out_last, "R1 idle outputs", int'({out_valid, out_last}), 0);
    check(stat_o == '0, "R1 status cleared", int'(stat_o), 0);
    @(negedge clk);

    rdy_mode = 0; run_page(1'b0, 5, 3, "R2 R3 R8");
    rdy_mode = 1; run_page(1'b1, 5, 3, "R4 R5 R8");
    rdy_mode = 2; run_page(1'b0, 1, 1, "R2 R9");
    rdy_mode = 1; run_page(1'b1, 16, 4, "R4 R9");
    rdy_mode = 1; run_page(1'b1, 3, 2, "R4 R5");
    rdy_mode = 1; run_page(1'b0, 16, 4, "R2 R7 R9");
    rdy_mode = 2; run_page(1'b1, 1, 1, "R4 R9");
    rdy_mode = 1; run_page(1'b0, 7, 2, "R2 R7");

    #3;
    check(!out_valid, "R4 idle after pages", int'(out_valid), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule